// File: doc/BRIEF.md
# Up/Down Potentiometer Step Sequencer

This block is the host-side controller for a digital potentiometer that is moved by three control lines: an active-low select, a direction level, and an increment strobe whose falling edge moves the wiper one tap. A command port with a valid/ready handshake accepts a step count, a direction and a commit flag. For each command the sequencer selects the device, sets the direction, issues the requested number of increment pulses, and then releases select.

The commit flag decides the level of the increment line when select rises. A high level asks the device to write its position into nonvolatile memory, which needs a long deselect time. A low level leaves the stored value alone and needs only a short deselect time. Every setup time, hold time, pulse width and deselect time is a parameter counted in system clocks. Each interval is enforced as its own minimum. The block stays busy, with command ready low, until the deselect time that belongs to the chosen release has passed. An optional shadow register follows the commanded steps and clamps at the ends of the tap range.

Top module: `pot_step_sequencer`

## Requirements
- R1: After reset, `pot_sel_n` and `pot_inc` are both 1, `cmd_ready` is 1, `busy` is 0, and `wiper_pos` equals `INIT_POS`.
- R2: While `pot_sel_n` is 0, `pot_dir_up` does not change. It takes the value of `cmd_up` (1 = toward the top tap) when select falls.
- R3: The first falling edge of `pot_inc` comes at least `max(T_SEL_SETUP, T_DIR_SETUP)` clocks after select falls. Every falling edge of `pot_inc` comes at least `T_DIR_SETUP` clocks after the last change of `pot_dir_up`.
- R4: While selected, each low phase of `pot_inc` lasts at least `T_INC_LOW` clocks and each high phase between pulses lasts at least `T_INC_HIGH` clocks. Consecutive falling edges are at least `T_INC_CYCLE` clocks apart.
- R5: The number of falling edges of `pot_inc` in one select window equals `cmd_steps`.
- R6: Select rises at least `T_REL` clocks after the last transition of `pot_inc` in the window.
- R7: When select rises, `pot_inc` equals `cmd_commit`: 1 requests a store, 0 skips it.
- R8: After select rises, `cmd_ready` stays low for at least `T_STORE` clocks after a store release and at least `T_NOSTORE` clocks after a no-store release.
- R9: A command with `cmd_steps` = 0 and `cmd_commit` = 1 still opens a select window with no increment pulses and releases it with `pot_inc` = 1.
- R10: A command with `cmd_steps` = 0 and `cmd_commit` = 0 is accepted as a no-op. Select stays high, `pot_inc` stays high, `wiper_pos` is unchanged, and `cmd_ready` stays high.
- R11: `cmd_ready` is low and `busy` is high while select is low, and from acceptance of a non-trivial command until its deselect time has finished.
- R12: `wiper_pos` moves by one for each pulse, in the direction of the command. It clamps at 0 and at `POS_MAX` (default 99), and it changes only while selected.
- R13: `pot_dir_up` changes no earlier than `T_DIR_HOLD` clocks after the last rising edge of `pot_inc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with valid |
| cmd_steps | input | STEP_W | Number of increment pulses |
| cmd_up | input | 1 | Direction, 1 = up |
| cmd_commit | input | 1 | 1 = store the position on release |
| busy | output | 1 | A command or its deselect time is in progress |
| pot_sel_n | output | 1 | Active-low device select |
| pot_inc | output | 1 | Increment strobe, the falling edge moves the wiper |
| pot_dir_up | output | 1 | Direction level to the device |
| wiper_pos | output | POS_W | Shadow of the expected wiper tap |

## Verification
The bound checker watches every cycle for the pin timing rules: select setup and direction setup before each falling strobe, low, high and cycle widths, the release delay after the last strobe edge, direction hold after a rising strobe, the deselect time before ready returns, ready being low while selected, and the shadow changing only while selected and staying within range. Only the bench scenarios can show that the pulse count and direction match each command, that the release level follows the commit flag, that a zero-step store still opens a window while a zero-step no-store does nothing, and that the shadow clamps at both ends after long runs.

// File: rtl/pot_seq_pkg.sv
package pot_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_LOW,
      ST_HIGH,
      ST_TAIL_HI,
      ST_TAIL_LO,
      ST_REL,
      ST_WAIT
   } pot_state_e;

   function automatic int unsigned umax2(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // Width needed to hold values 0..v
   function automatic int unsigned bits_for(int unsigned v);
      int unsigned w;
      w = 1;
      while ((64'd1 << w) <= 64'(v)) w++;
      return w;
   endfunction

endpackage

// File: rtl/pot_interval_timer.sv
module pot_interval_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   // A load of N leaves expired high in the N-th cycle after the load edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val - CNT_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/pot_wiper_shadow.sv
module pot_wiper_shadow #(
   parameter int unsigned POS_W    = 7,
   parameter int unsigned POS_MAX  = 99,
   parameter int unsigned INIT_POS = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             up,
   output logic [POS_W-1:0] pos
);
   localparam logic [POS_W-1:0] TOP = POS_W'(POS_MAX);

   logic [POS_W-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= POS_W'(INIT_POS);
      end else if (step) begin
         if (up) begin
            if (pos_q != TOP) pos_q <= pos_q + POS_W'(1);
         end else begin
            if (pos_q != '0) pos_q <= pos_q - POS_W'(1);
         end
      end
   end

   assign pos = pos_q;
endmodule

// File: rtl/pot_seq_fsm.sv
module pot_seq_fsm
   import pot_seq_pkg::*;
#(
   parameter int unsigned STEP_W      = 8,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SETUP_CLK   = 4,
   parameter int unsigned LOW_CLK     = 4,
   parameter int unsigned HIGH_CLK    = 4,
   parameter int unsigned TAIL_CLK    = 4,
   parameter int unsigned STORE_CLK   = 16,
   parameter int unsigned NOSTORE_CLK = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [STEP_W-1:0] cmd_steps,
   input  logic              cmd_up,
   input  logic              cmd_commit,
   output logic              cmd_ready,
   output logic              sel_n,
   output logic              inc,
   output logic              dir_up,
   output logic              step_pulse,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   input  logic              tmr_expired
);
   pot_state_e        state_q, state_d;
   logic [STEP_W-1:0] left_q, left_d;
   logic              commit_q, commit_d;
   logic              dir_q, dir_d;
   logic              sel_n_q, inc_q;

   function automatic logic [CNT_W-1:0] dur_of(pot_state_e s, logic commit);
      case (s)
         ST_SETUP:              return CNT_W'(SETUP_CLK);
         ST_LOW:                return CNT_W'(LOW_CLK);
         ST_HIGH:               return CNT_W'(HIGH_CLK);
         ST_TAIL_HI, ST_TAIL_LO: return CNT_W'(TAIL_CLK);
         ST_WAIT:               return commit ? CNT_W'(STORE_CLK) : CNT_W'(NOSTORE_CLK);
         default:               return CNT_W'(1);
      endcase
   endfunction

   always_comb begin
      state_d    = state_q;
      left_d     = left_q;
      commit_d   = commit_q;
      dir_d      = dir_q;
      step_pulse = 1'b0;
      case (state_q)
         ST_IDLE: begin
            // zero steps without a store is accepted and does nothing
            if (cmd_valid && (cmd_steps != '0 || cmd_commit)) begin
               state_d  = ST_SETUP;
               left_d   = cmd_steps;
               commit_d = cmd_commit;
               dir_d    = cmd_up;
            end
         end
         ST_SETUP: begin
            if (tmr_expired) begin
               if (left_q == '0) begin
                  state_d = ST_TAIL_HI;
               end else begin
                  state_d    = ST_LOW;
                  left_d     = left_q - STEP_W'(1);
                  step_pulse = 1'b1;
               end
            end
         end
         ST_LOW: begin
            if (tmr_expired) begin
               state_d = (left_q == '0 && !commit_q) ? ST_TAIL_LO : ST_HIGH;
            end
         end
         ST_HIGH: begin
            if (tmr_expired) begin
               if (left_q == '0) begin
                  state_d = ST_TAIL_HI;
               end else begin
                  state_d    = ST_LOW;
                  left_d     = left_q - STEP_W'(1);
                  step_pulse = 1'b1;
               end
            end
         end
         ST_TAIL_HI, ST_TAIL_LO: begin
            if (tmr_expired) state_d = ST_REL;
         end
         ST_REL: begin
            if (tmr_expired) state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (tmr_expired) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign tmr_load = (state_d != state_q);
   assign tmr_val  = dur_of(state_d, commit_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         left_q   <= '0;
         commit_q <= 1'b0;
         dir_q    <= 1'b0;
         sel_n_q  <= 1'b1;
         inc_q    <= 1'b1;
      end else begin
         state_q  <= state_d;
         left_q   <= left_d;
         commit_q <= commit_d;
         dir_q    <= dir_d;
         sel_n_q  <= (state_d == ST_IDLE) || (state_d == ST_REL) || (state_d == ST_WAIT);
         if (state_d == ST_LOW || state_d == ST_TAIL_LO) inc_q <= 1'b0;
         else if (state_d != ST_REL)                     inc_q <= 1'b1;
      end
   end

   assign cmd_ready = (state_q == ST_IDLE);
   assign sel_n     = sel_n_q;
   assign inc       = inc_q;
   assign dir_up    = dir_q;
endmodule

// File: rtl/pot_step_sequencer.sv
module pot_step_sequencer
   import pot_seq_pkg::*;
#(
   parameter int unsigned STEP_W      = 8,
   parameter int unsigned POS_MAX     = 99,
   parameter int unsigned INIT_POS    = 0,
   parameter bit          TRACK_POS   = 1'b1,
   parameter int unsigned T_SEL_SETUP = 3,
   parameter int unsigned T_DIR_SETUP = 50,
   parameter int unsigned T_DIR_HOLD  = 5,
   parameter int unsigned T_INC_LOW   = 48,
   parameter int unsigned T_INC_HIGH  = 48,
   parameter int unsigned T_INC_CYCLE = 100,
   parameter int unsigned T_REL       = 50,
   parameter int unsigned T_STORE     = 500000,
   parameter int unsigned T_NOSTORE   = 5,
   localparam int unsigned POS_W      = bits_for(POS_MAX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [STEP_W-1:0] cmd_steps,
   input  logic              cmd_up,
   input  logic              cmd_commit,
   output logic              busy,
   output logic              pot_sel_n,
   output logic              pot_inc,
   output logic              pot_dir_up,
   output logic [POS_W-1:0]  wiper_pos
);
   localparam int unsigned SETUP_CLK   = umax2(T_SEL_SETUP, T_DIR_SETUP);
   localparam int unsigned HIGH_CLK    = umax2(T_INC_HIGH,
                                  (T_INC_CYCLE > T_INC_LOW) ? T_INC_CYCLE - T_INC_LOW : 0);
   localparam int unsigned STORE_CLK   = umax2(T_STORE, T_DIR_HOLD);
   localparam int unsigned NOSTORE_CLK = umax2(T_NOSTORE, T_DIR_HOLD);
   localparam int unsigned MAX_DUR     = umax2(umax2(umax2(SETUP_CLK, T_INC_LOW),
                                               umax2(HIGH_CLK, T_REL)),
                                               umax2(STORE_CLK, NOSTORE_CLK));
   localparam int unsigned CNT_W       = bits_for(MAX_DUR);

   // Elaboration-time parameter checks
   if (T_SEL_SETUP == 0 || T_DIR_SETUP == 0 || T_INC_LOW == 0 || T_INC_HIGH == 0 ||
       T_REL == 0 || T_STORE == 0 || T_NOSTORE == 0) begin : g_bad_interval
      $error("pot_step_sequencer: every interval must be at least one clock");
   end
   if (INIT_POS > POS_MAX) begin : g_bad_init
      $error("pot_step_sequencer: INIT_POS exceeds POS_MAX");
   end
   if (STEP_W == 0) begin : g_bad_step_w
      $error("pot_step_sequencer: STEP_W must be nonzero");
   end

   logic             tmr_load, tmr_expired, step_pulse;
   logic [CNT_W-1:0] tmr_val;

   pot_seq_fsm #(
      .STEP_W     (STEP_W),
      .CNT_W      (CNT_W),
      .SETUP_CLK  (SETUP_CLK),
      .LOW_CLK    (T_INC_LOW),
      .HIGH_CLK   (HIGH_CLK),
      .TAIL_CLK   (T_REL),
      .STORE_CLK  (STORE_CLK),
      .NOSTORE_CLK(NOSTORE_CLK)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_steps  (cmd_steps),
      .cmd_up     (cmd_up),
      .cmd_commit (cmd_commit),
      .cmd_ready  (cmd_ready),
      .sel_n      (pot_sel_n),
      .inc        (pot_inc),
      .dir_up     (pot_dir_up),
      .step_pulse (step_pulse),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val),
      .tmr_expired(tmr_expired)
   );

   pot_interval_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .expired (tmr_expired)
   );

   assign busy = ~cmd_ready;

   if (TRACK_POS) begin : g_shadow
      pot_wiper_shadow #(
         .POS_W   (POS_W),
         .POS_MAX (POS_MAX),
         .INIT_POS(INIT_POS)
      ) u_shadow (
         .clk  (clk),
         .rst_n(rst_n),
         .step (step_pulse),
         .up   (pot_dir_up),
         .pos  (wiper_pos)
      );
   end else begin : g_no_shadow
      assign wiper_pos = POS_W'(INIT_POS);
   end
endmodule

// File: rtl/pot_step_sequencer_checker.sv
module pot_step_sequencer_checker #(
   parameter int unsigned POS_W       = 7,
   parameter int unsigned POS_MAX     = 99,
   parameter int unsigned T_SEL_SETUP = 3,
   parameter int unsigned T_DIR_SETUP = 50,
   parameter int unsigned T_DIR_HOLD  = 5,
   parameter int unsigned T_INC_LOW   = 48,
   parameter int unsigned T_INC_HIGH  = 48,
   parameter int unsigned T_INC_CYCLE = 100,
   parameter int unsigned T_REL       = 50,
   parameter int unsigned T_STORE     = 500000,
   parameter int unsigned T_NOSTORE   = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_ready,
   input logic             busy,
   input logic             pot_sel_n,
   input logic             pot_inc,
   input logic             pot_dir_up,
   input logic [POS_W-1:0] wiper_pos
);
   localparam int unsigned SETUP_MIN = (T_SEL_SETUP > T_DIR_SETUP) ? T_SEL_SETUP : T_DIR_SETUP;
   localparam int unsigned SAT       = 32'hFFFF_FFFF;

   logic sel_q, inc_q, dir_q, store_q;
   int unsigned since_sel, since_fall, since_rise, since_edge, since_dir, since_rel;

   // Each counter reads 1 at the first edge that sees its event, so at a later
   // edge it holds the distance in clocks between the two transitions.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b1; inc_q <= 1'b1; dir_q <= 1'b0; store_q <= 1'b0;
         since_sel <= SAT; since_fall <= SAT; since_rise <= SAT;
         since_edge <= SAT; since_dir <= SAT; since_rel <= SAT;
      end else begin
         sel_q <= pot_sel_n; inc_q <= pot_inc; dir_q <= pot_dir_up;
         since_sel  <= (sel_q && !pot_sel_n) ? 1 : (since_sel  == SAT ? SAT : since_sel + 1);
         since_fall <= (inc_q && !pot_inc)   ? 1 : (since_fall == SAT ? SAT : since_fall + 1);
         since_rise <= (!inc_q && pot_inc)   ? 1 : (since_rise == SAT ? SAT : since_rise + 1);
         since_edge <= (inc_q != pot_inc)    ? 1 : (since_edge == SAT ? SAT : since_edge + 1);
         since_dir  <= (dir_q != pot_dir_up) ? 1 : (since_dir  == SAT ? SAT : since_dir + 1);
         since_rel  <= (!sel_q && pot_sel_n) ? 1 : (since_rel  == SAT ? SAT : since_rel + 1);
         if (!sel_q && pot_sel_n) store_q <= pot_inc;
      end
   end

   assert_dir_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pot_sel_n && !$past(pot_sel_n)) |-> $stable(pot_dir_up));

   assert_sel_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pot_inc) |-> (since_sel >= SETUP_MIN));

   assert_dir_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pot_inc) |-> (since_dir >= T_DIR_SETUP));

   assert_low_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pot_inc) && !pot_sel_n) |-> (since_fall >= T_INC_LOW));

   assert_high_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pot_inc) |-> (since_rise >= T_INC_HIGH));

   assert_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pot_inc) |-> (since_fall >= T_INC_CYCLE));

   assert_release_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pot_sel_n) |-> (since_edge >= T_REL));

   assert_deselect_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_ready) |-> (since_rel >= (store_q ? T_STORE : T_NOSTORE)));

   assert_busy_when_selected_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pot_sel_n |-> (!cmd_ready && busy));

   assert_pos_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wiper_pos <= POS_W'(POS_MAX));

   assert_pos_moves_selected_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(wiper_pos) |-> !pot_sel_n);

   assert_dir_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(pot_dir_up) |-> (since_rise >= T_DIR_HOLD));
endmodule

bind pot_step_sequencer pot_step_sequencer_checker #(
   .POS_W      (POS_W),
   .POS_MAX    (POS_MAX),
   .T_SEL_SETUP(T_SEL_SETUP),
   .T_DIR_SETUP(T_DIR_SETUP),
   .T_DIR_HOLD (T_DIR_HOLD),
   .T_INC_LOW  (T_INC_LOW),
   .T_INC_HIGH (T_INC_HIGH),
   .T_INC_CYCLE(T_INC_CYCLE),
   .T_REL      (T_REL),
   .T_STORE    (T_STORE),
   .T_NOSTORE  (T_NOSTORE)
) u_pot_step_sequencer_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .busy      (busy),
   .pot_sel_n (pot_sel_n),
   .pot_inc   (pot_inc),
   .pot_dir_up(pot_dir_up),
   .wiper_pos (wiper_pos)
);

// File: tb/test_pot_step_sequencer.sv
module test_pot_step_sequencer;
   localparam int STEP_W  = 8;
   localparam int POS_MAX = 99;
   localparam int POS_W   = 7;
   localparam int TSS = 2, TDS = 4, TDH = 3, TLO = 3, THI = 3, TCY = 8;
   localparam int TRL = 4, TST = 200, TNS = 5;
   localparam int SETUP_MIN = (TSS > TDS) ? TSS : TDS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [STEP_W-1:0] cmd_steps = '0;
   logic cmd_up = 1'b0, cmd_commit = 1'b0;
   logic cmd_ready, busy, pot_sel_n, pot_inc, pot_dir_up;
   logic [POS_W-1:0] wiper_pos;

   always #10 clk = ~clk;   // 50 MHz

   pot_step_sequencer #(
      .STEP_W(STEP_W), .POS_MAX(POS_MAX), .INIT_POS(0), .TRACK_POS(1'b1),
      .T_SEL_SETUP(TSS), .T_DIR_SETUP(TDS), .T_DIR_HOLD(TDH),
      .T_INC_LOW(TLO), .T_INC_HIGH(THI), .T_INC_CYCLE(TCY),
      .T_REL(TRL), .T_STORE(TST), .T_NOSTORE(TNS)
   ) i_pot_step_sequencer (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_steps(cmd_steps), .cmd_up(cmd_up), .cmd_commit(cmd_commit),
      .busy(busy), .pot_sel_n(pot_sel_n), .pot_inc(pot_inc),
      .pot_dir_up(pot_dir_up), .wiper_pos(wiper_pos)
   );

   typedef struct { int steps; bit up; bit commit; int pos; } exp_t;
   exp_t exp_q[$];

   int total = 0, fails = 0;
   int model_pos = 0;
   int windows = 0;
   bit done = 1'b0;

   task automatic chk(bit ok, string req, longint act, longint expv);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Driver: one handshake, expected result pushed to the scoreboard
   task automatic send(int steps, bit up, bit commit);
      exp_t e;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_steps = STEP_W'(steps); cmd_up = up; cmd_commit = commit;
      if (steps != 0 || commit) begin
         for (int i = 0; i < steps; i++) begin
            if (up && model_pos < POS_MAX) model_pos++;
            else if (!up && model_pos > 0) model_pos--;
         end
         e.steps = steps; e.up = up; e.commit = commit; e.pos = model_pos;
         exp_q.push_back(e);
      end
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   // Monitor: measures pin timing and compares each select window
   longint cyc = 0;
   longint t_sel = 0, t_fall = -1000, t_rise = -1000, t_edge = -1000, t_dir = -1000, t_rel = 0;
   logic p_sel = 1'b1, p_inc = 1'b1, p_dir = 1'b0, p_rdy = 1'b1;
   int pulses = 0;
   bit win_dir = 1'b0, dir_moved = 1'b0, rel_store = 1'b0, pend_rdy = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (pot_dir_up != p_dir) begin
            chk(cyc - t_rise >= TDH, "R13 dir hold", cyc - t_rise, TDH);
            if (!pot_sel_n && !p_sel) dir_moved = 1'b1;
            t_dir = cyc;
         end
         if (p_sel && !pot_sel_n) begin
            t_sel = cyc; pulses = 0; win_dir = pot_dir_up; dir_moved = 1'b0;
            chk(!cmd_ready && busy, "R11 ready low while selected", cmd_ready, 0);
         end
         if (p_inc && !pot_inc && !pot_sel_n) begin
            pulses++;
            if (pulses == 1)
               chk(cyc - t_sel >= SETUP_MIN, "R3 select setup", cyc - t_sel, SETUP_MIN);
            else begin
               chk(cyc - t_fall >= TCY, "R4 cycle", cyc - t_fall, TCY);
               chk(cyc - t_rise >= THI, "R4 high width", cyc - t_rise, THI);
            end
            chk(cyc - t_dir >= TDS, "R3 dir setup", cyc - t_dir, TDS);
            t_fall = cyc; t_edge = cyc;
         end
         if (!p_inc && pot_inc) begin
            if (!pot_sel_n) begin
               chk(cyc - t_fall >= TLO, "R4 low width", cyc - t_fall, TLO);
               t_edge = cyc;
            end
            t_rise = cyc;
         end
         if (!p_sel && pot_sel_n) begin
            exp_t e;
            windows++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5 unexpected window", windows, 0);
            end else begin
               e = exp_q.pop_front();
               chk(pulses == e.steps, "R5 pulse count", pulses, e.steps);
               if (e.steps != 0) begin
                  chk(win_dir == e.up && !dir_moved, "R2 direction", win_dir, e.up);
                  chk(cyc - t_edge >= TRL, "R6 release gap", cyc - t_edge, TRL);
               end else begin
                  chk(pot_inc == 1'b1, "R9 zero-step store release", pot_inc, 1);
               end
               chk(pot_inc == e.commit, "R7 release level", pot_inc, e.commit);
               chk(int'(wiper_pos) == e.pos, "R12 position", wiper_pos, e.pos);
            end
            t_rel = cyc; rel_store = pot_inc; pend_rdy = 1'b1;
         end
         if (!p_rdy && cmd_ready && pend_rdy) begin
            chk(cyc - t_rel >= (rel_store ? TST : TNS), "R8 deselect time",
                cyc - t_rel, rel_store ? TST : TNS);
            pend_rdy = 1'b0;
         end
         p_sel = pot_sel_n; p_inc = pot_inc; p_dir = pot_dir_up; p_rdy = cmd_ready;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(pot_sel_n == 1'b1, "R1 select idle", pot_sel_n, 1);
      chk(pot_inc == 1'b1, "R1 inc idle", pot_inc, 1);
      chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(wiper_pos == 0, "R1 position", wiper_pos, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      send(5, 1'b1, 1'b0);
      send(3, 1'b0, 1'b1);
      send(0, 1'b1, 1'b1);          // R9
      send(1, 1'b1, 1'b0);
      begin : noop_r10
         int w0, p0;
         @(negedge clk);
         while (!cmd_ready) @(negedge clk);
         w0 = windows; p0 = int'(wiper_pos);
         send(0, 1'b0, 1'b0);       // R10
         chk(cmd_ready == 1'b1, "R10 ready stays high", cmd_ready, 1);
         repeat (12) @(negedge clk);
         chk(windows == w0 && pot_sel_n == 1'b1, "R10 no window", windows, w0);
         chk(pot_inc == 1'b1, "R10 inc untouched", pot_inc, 1);
         chk(int'(wiper_pos) == p0, "R10 position unchanged", wiper_pos, p0);
      end
      send(120, 1'b1, 1'b0);        // clamps at top, R12
      send(2, 1'b1, 1'b1);
      send(110, 1'b0, 1'b0);        // clamps at bottom, R12
      send(1, 1'b0, 1'b1);
      send(2, 1'b1, 1'b0);
      @(negedge clk);
      while (exp_q.size() != 0 || !cmd_ready) @(negedge clk);
      repeat (20) @(negedge clk);
      chk(windows == 9, "R5 window count", windows, 9);
      chk(wiper_pos == 2, "R12 final position", wiper_pos, 2);
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         chk(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule